// File: doc/BRIEF.md
# Shared-Line SCL Clock Synchronizer

This block generates the serial clock for one master on a two-wire bus whose clock line is wired-AND: any device can pull it low, and it reads high only when every device has let go. The master does not free-run a divider. It follows the line. It holds the line low for a programmed number of cycles. It then lets go and waits until the line actually reads high before it counts a programmed high time. When that high count runs out, it pulls the line low again.

If another master pulls the line low while this one is still counting high, the block starts its low phase at once, with a fresh low count. Several such masters therefore agree on one bus clock. That clock has the longest low phase and the shortest high phase of the masters taking part. A slave that holds the line low simply extends the low phase, because the block will not count high until it sees the line released.

The bit engine receives one-cycle strobes. One marks the start of high counting, the point at which data can be sampled. The other marks the start of the low phase, the point at which data can change. The `scl_i` input is assumed to be already synchronized to `clk_i`.

Top module: `scl_clock_sync`

## Requirements
- R1: After reset, `scl_pull_o`, `rise_o` and `fall_o` are all 0.
- R2: While `en_i` is 0, `scl_pull_o` is 0 in that same cycle. From the first clock edge with `en_i` at 0, `rise_o` and `fall_o` stay 0 and activity on the line has no effect on the outputs.
- R3: Running alone, the master pulls the line low for exactly `low_cycles_i` clock cycles per low phase. A value of 0 acts as 1.
- R4: Running alone, the line stays high for `high_cycles_i` + 1 cycles per high phase. The extra cycle is the one in which the release is observed. A value of 0 acts as 1.
- R5: If the line falls while the master is counting high, the master enters its low phase on the next edge with its full low count. The bus low time is then the larger of the leader's low count and the follower's low count + 1.
- R6: After its low count ends, the master keeps the line released and does not start high counting while the line reads low. A device holding the line for S cycles beyond the fall strobe gives a low phase of max(`low_cycles_i`, S + 1).
- R7: With two masters, the bus high phase is the smaller of the two high counts + 1.
- R8: `rise_o` is a one-cycle pulse in the first cycle of high counting. In that cycle the line is high and the master is not pulling.
- R9: `fall_o` is a one-cycle pulse in the first cycle of the low phase. In that cycle `scl_pull_o` is 1 unless `en_i` is 0.
- R10: `rise_o` and `fall_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enables the clock generator. When low, the line is released and the counter is cleared. |
| low_cycles_i | input | CNT_W | Low phase length in clock cycles (0 acts as 1) |
| high_cycles_i | input | CNT_W | High count length in clock cycles (0 acts as 1) |
| scl_i | input | 1 | Synchronized level of the shared clock line |
| scl_pull_o | output | 1 | Open-drain enable: 1 pulls the line low |
| rise_o | output | 1 | One-cycle strobe at the start of high counting |
| fall_o | output | 1 | One-cycle strobe at the start of the low phase |

## Verification
The assertions are evaluated on every cycle. They check the following:
- `rise_o` and `fall_o` are exclusive.
- A rise strobe appears only after the line was sampled high.
- A fall strobe coincides with the pull.
- A disabled block goes quiet on the next edge.
- A master waiting on a low line neither pulls nor strobes.
- An idle counter stays at zero.

Some behaviour only the bench scenarios can show, because it depends on how two generators and a stretching slave interact on one wired-AND line. This covers the exact low and high phase lengths, the max-of-lows and min-of-highs results, the one-cycle follower delay, stretching by a slave, and the zero-count edge cases.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_WAIT = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOW  = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_line_edge.sv
module scl_line_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic fell_o
);
  logic scl_q;

  // idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_q <= 1'b1;
    else         scl_q <= scl_i;
  end

  assign fell_o = scl_q & ~scl_i;
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // an expired counter must not wrap around
  assert_hold_at_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync
  import scl_sync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] low_cycles_i,
  input  logic [CNT_W-1:0] high_cycles_i,
  input  logic             scl_i,
  output logic             scl_pull_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  phase_e           st_q, st_d;
  logic             rise_q, rise_d, fall_q, fall_d;
  logic             ctr_clr, ctr_load, ctr_done, line_fell;
  logic [CNT_W-1:0] ctr_val, lo_load, hi_load;

  // counter runs to zero, so load length-1; zero length saturates to one cycle
  assign lo_load = (low_cycles_i  == CNT_ZERO) ? CNT_ZERO : low_cycles_i  - 1'b1;
  assign hi_load = (high_cycles_i == CNT_ZERO) ? CNT_ZERO : high_cycles_i - 1'b1;

  scl_line_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .fell_o (line_fell)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (ctr_clr),
    .load_i     (ctr_load),
    .load_val_i (ctr_val),
    .done_o     (ctr_done)
  );

  always_comb begin
    st_d     = st_q;
    rise_d   = 1'b0;
    fall_d   = 1'b0;
    ctr_clr  = 1'b0;
    ctr_load = 1'b0;
    ctr_val  = hi_load;
    if (!en_i) begin
      st_d    = PH_OFF;
      ctr_clr = 1'b1;
    end else begin
      unique case (st_q)
        PH_OFF:  st_d = PH_WAIT;
        PH_WAIT: if (scl_i) begin
          st_d     = PH_HIGH;
          ctr_load = 1'b1;
          ctr_val  = hi_load;
          rise_d   = 1'b1;
        end
        // own count expired or another device pulled first: restart low count
        PH_HIGH: if (line_fell || ctr_done) begin
          st_d     = PH_LOW;
          ctr_load = 1'b1;
          ctr_val  = lo_load;
          fall_d   = 1'b1;
        end
        PH_LOW:  if (ctr_done) st_d = PH_WAIT;
        default: st_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_OFF;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign scl_pull_o = (st_q == PH_LOW) && en_i;
  assign rise_o     = rise_q;
  assign fall_o     = fall_q;

  assert_off_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rise_o && !fall_o && !scl_pull_o));

  assert_wait_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_WAIT && !scl_i && en_i) |=> (!scl_pull_o && !rise_o));

  assert_rise_after_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> ($past(scl_i) && !scl_pull_o));

  assert_fall_with_pull_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (scl_pull_o || !en_i));

  assert_pull_start_strobed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_pull_o) |-> fall_o);

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: tb/scl_clock_sync_test.sv
module scl_clock_sync_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             a_en = 1'b0, b_en = 1'b0;
  logic [CNT_W-1:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
  logic             a_pull, a_rise, a_fall, b_pull, b_rise, b_fall;
  logic             slave_pull = 1'b0;
  logic             scl_line;

  assign scl_line = !(a_pull || b_pull || slave_pull);

  scl_clock_sync #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(a_en),
    .low_cycles_i(a_lo), .high_cycles_i(a_hi), .scl_i(scl_line),
    .scl_pull_o(a_pull), .rise_o(a_rise), .fall_o(a_fall)
  );

  scl_clock_sync #(.CNT_W(CNT_W)) peer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(b_en),
    .low_cycles_i(b_lo), .high_cycles_i(b_hi), .scl_i(scl_line),
    .scl_pull_o(b_pull), .rise_o(b_rise), .fall_o(b_fall)
  );

  typedef struct {
    bit    lvl;
    int    len;
    string req;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;

  bit    mon_on = 0, skip = 0, chk_off = 0, strobe_on = 0;
  bit    cur = 1;
  int    run = 0;
  item_t mon_it;

  bit    slave_arm = 0;
  int    slave_len = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: measure line phases and compare against the scoreboard queue
  always @(negedge clk) begin
    if (!mon_on) begin
      run = 0;
      cur = scl_line;
    end else if (scl_line == cur) begin
      run++;
    end else begin
      if (skip) skip = 0;
      else if (exp_q.size() > 0) begin
        mon_it = exp_q.pop_front();
        chk(mon_it.lvl == cur, mon_it.req, int'(cur), int'(mon_it.lvl), "phase level");
        chk(mon_it.len == run, mon_it.req, run, mon_it.len, "phase length");
      end
      cur = scl_line;
      run = 1;
    end
    if (strobe_on && a_rise)
      chk(scl_line && !a_pull, "R8", int'(scl_line), 1, "line high at rise strobe");
    if (strobe_on && a_fall)
      chk(a_pull || !a_en, "R9", int'(a_pull), 1, "pull at fall strobe");
    if (strobe_on && (a_rise || a_fall))
      chk(!(a_rise && a_fall), "R10", int'(a_rise && a_fall), 0, "strobes exclusive");
    if (chk_off)
      chk(!a_pull && !a_rise && !a_fall, "R2", int'({a_pull, a_rise, a_fall}), 0, "disabled outputs");
  end

  // slave stretching the low phase after each fall strobe
  initial begin
    forever begin
      @(negedge clk);
      if (slave_arm && a_fall) begin
        @(posedge clk); #1 slave_pull = 1'b1;
        repeat (slave_len) @(posedge clk);
        #1 slave_pull = 1'b0;
      end
    end
  end

  task automatic run_case(input int alo, input int ahi, input bit use_a,
                          input int blo, input int bhi, input bit use_b,
                          input int exp_lo, input int exp_hi, input int n,
                          input string req_lo, input string req_hi, input int s_len);
    @(posedge clk); #2;
    a_lo = alo[CNT_W-1:0]; a_hi = ahi[CNT_W-1:0];
    b_lo = blo[CNT_W-1:0]; b_hi = bhi[CNT_W-1:0];
    slave_len = s_len;
    slave_arm = (s_len > 0);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{1'b0, exp_lo, req_lo});
      exp_q.push_back('{1'b1, exp_hi, req_hi});
    end
    skip = 1; mon_on = 1;
    a_en = use_a; b_en = use_b;
    if (!use_a) begin
      @(posedge clk); #2 chk_off = 1;
    end
    while (exp_q.size() > 0) @(posedge clk);
    #2;
    mon_on = 0; slave_arm = 0; chk_off = 0;
    a_en = 0; b_en = 0;
    while (slave_pull) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!a_pull && !a_rise && !a_fall, "R1", int'({a_pull, a_rise, a_fall}), 0, "reset outputs");
    strobe_on = 1;
    // alone: low = L, high = H+1
    run_case(3, 4, 1, 0, 0, 0, 3, 5, 3, "R3", "R4", 0);
    run_case(0, 0, 1, 0, 0, 0, 1, 2, 3, "R3", "R4", 0);
    // two masters, this one leads (smaller high)
    run_case(5, 2, 1, 3, 6, 1, 5, 3, 3, "R5", "R7", 0);
    // peer leads; this one follows one cycle late
    run_case(2, 7, 1, 6, 3, 1, 6, 4, 3, "R5", "R7", 0);
    // equal highs fall together
    run_case(4, 4, 1, 2, 4, 1, 4, 5, 3, "R5", "R7", 0);
    // follower's low + 1 dominates
    run_case(2, 3, 1, 5, 5, 1, 6, 4, 3, "R5", "R7", 0);
    // slave stretching
    run_case(2, 3, 1, 0, 0, 0, 7, 4, 3, "R6", "R4", 6);
    run_case(5, 2, 1, 0, 0, 0, 5, 3, 3, "R6", "R4", 2);
    // disabled master ignores the busy line
    run_case(0, 0, 0, 3, 2, 1, 3, 3, 3, "R2", "R2", 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule